// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a memory-mapped slave on a simple 32-bit request/response bus. It owns two alias windows of 32 MB each. In a window, every aligned 32-bit word stands for one single bit of a backing region. A read of an alias word makes one fetch through a master port. The fetch reads a byte, a halfword or a word of the backing region, and the bridge answers 0 or 1 according to the chosen bit. A write of an alias word makes a locked read-modify-write on the master port. It sets or clears that one bit according to bit 0 of the write data, and the rest of the unit keeps its value.

The alias window at 0x22000000 maps onto the region at 0x20000000. The window at 0x42000000 maps onto the region at 0x40000000. Software turns single-bit updates into plain stores with this block, and the update stays safe against other bus masters because the master port stays locked from the fetch until the write-back. Both sides use a request/ready handshake. A request is held stable until ready is high for one cycle. The slave address is a word address, so alias accesses are always word aligned.

Top module: `bitband_bridge`

## Requirements
- R1: The bridge accepts only word addresses whose byte address lies in 0x22000000–0x23FFFFFF or in 0x42000000–0x43FFFFFF. Any other address gets an error response with read data 0, and no master request is issued.
- R2: The backing byte address is the region base (0x20000000 or 0x40000000) ORed with byte-address bits [24:5] placed at bits [19:0]. For halfword accesses bit 0 of that address is cleared, and for word accesses bits [1:0] are cleared.
- R3: The size code is 0 for byte, 1 for halfword and 2 for word. The bit index within the unit is byte-address bits [4:2] for a byte, [5:2] for a halfword and [6:2] for a word. Size code 3 is rejected like an address miss.
- R4: The master bus is little-endian with byte enables m_be[3:0], where lane k holds bits 8k+7..8k. A byte access enables only lane addr[1:0]. A halfword access enables lanes 1:0, or lanes 3:2 when addr[1] is set. A word access enables all four lanes.
- R5: An alias read returns 1 in bit 0 of s_rdata when the selected bit of the fetched unit is set, and 0 otherwise. Bits 31:1 of s_rdata are always 0.
- R6: An alias write fetches the unit, then writes it back to the same address with the same size and byte enables. The selected bit takes the value of bit 0 of the write data, and every other bit keeps its fetched value.
- R7: m_lock is high on the fetch and on the write-back of an alias write, and the write-back follows the fetch with no other master request in between. A plain alias read is not locked.
- R8: When the master signals an error on the fetch, the slave gets an error response with read data 0 and no write-back is issued. An error on the write-back is also returned as a slave error.
- R9: s_ready is high for exactly one cycle per request, and only after the master-side transfers have completed. While m_req is high and m_ready is low, the master request stays stable.
- R10: While reset is applied, and in the first cycle after it, s_ready, m_req and m_lock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_req | input | 1 | Slave request, held until s_ready |
| s_we | input | 1 | Slave write (1) or read (0) |
| s_word_addr | input | 30 | Slave byte address bits 31:2 |
| s_size | input | 2 | Target unit size code (0 byte, 1 half, 2 word) |
| s_wbit | input | 1 | Bit 0 of the slave write data |
| s_ready | output | 1 | One-cycle response strobe |
| s_rdata | output | 32 | Response data (bit value in bit 0) |
| s_err | output | 1 | Error response, valid with s_ready |
| m_req | output | 1 | Master request, held until m_ready |
| m_we | output | 1 | Master write (1) or read (0) |
| m_lock | output | 1 | Master port locked for a read-modify-write |
| m_addr | output | 32 | Master byte address |
| m_size | output | 2 | Master unit size code |
| m_be | output | 4 | Master byte-lane enables |
| m_wdata | output | 32 | Master write data |
| m_ready | input | 1 | Master transfer complete |
| m_rdata | input | 32 | Master read data (full bus word) |
| m_err | input | 1 | Master transfer error |

## Verification
A wrong latched bit position shows in two places. It gives the wrong value in s_rdata[0] in the response cycle, and on a write it puts the change in the wrong bit of m_wdata, which is visible at the write-back handshake one transfer earlier. A wrong target address, size or lane mask shows at the very first master handshake of the access. A sequencer that drops the lock or leaves out the write-back shows as a master transfer that does not match the expected list, before the slave response arrives. A sequencer that starts a transfer on a miss or after a fetch error shows as an unexpected master transfer at the moment the bus model completes it.

// File: rtl/bb_pkg.sv
// Shared definitions for the bit-band alias bridge.
// Assumes a 32-bit byte-addressed bus and 32 MB alias windows.
package bb_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int WADDR_W = ADDR_W - 2;          // slave word-address width
    localparam int WIN_W   = 25;                  // alias window offset bits
    localparam int TAG_W   = ADDR_W - WIN_W;      // window tag bits
    localparam int POS_W   = $clog2(DATA_W);      // bit position on the bus
    localparam int BE_W    = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } bb_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_DONE  = 2'd3
    } bb_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  pos;
        logic [BE_W-1:0]   be;
        bb_size_e          size;
    } bb_target_t;
endpackage

// File: rtl/bb_alias_decode.sv
// Window decoder: compares the slave address tag with every alias window
// and supplies the matching backing-region base.
// Assumes the windows do not overlap, so at most one matches.
module bb_alias_decode
    import bb_pkg::*;
#(
    parameter int                       NUM_WIN    = 2,
    parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_MAP  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*ADDR_W-1:0] TARGET_MAP = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [WADDR_W-1:0] word_addr,
    input  bb_size_e           size,
    output logic               hit,
    output logic [ADDR_W-1:0]  base
);
    localparam int TAG_LSB = WIN_W - 2;   // tag position inside the word address

    logic [NUM_WIN-1:0] match;

    // One tag comparator per window.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign match[g] = (word_addr[WADDR_W-1:TAG_LSB] ==
                           ALIAS_MAP[g*ADDR_W + WIN_W +: TAG_W]);
    end

    // Select the base of the matching window; reject a bad size code.
    always_comb begin
        base = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (match[i]) base = base | TARGET_MAP[i*ADDR_W +: ADDR_W];
        end
        hit = (|match) && (size != SZ_BAD);
    end
endmodule

// File: rtl/bb_lane_map.sv
// Target mapper: builds the backing address, the bit position on the
// little-endian data bus and the byte-lane enables for one alias access.
// Assumes the size code has been checked by the decoder.
module bb_lane_map
    import bb_pkg::*;
(
    input  logic [WADDR_W-1:0] word_addr,
    input  bb_size_e           size,
    input  logic [ADDR_W-1:0]  base,
    output bb_target_t         tgt
);
    localparam int UNIT_W = WIN_W - 5;    // offset bits that select the byte

    logic [ADDR_W-1:0] unit;

    // Byte address of the backing unit, then per-size alignment and lanes.
    always_comb begin
        unit     = base | {{(ADDR_W-UNIT_W){1'b0}}, word_addr[WIN_W-3:3]};
        tgt.size = size;
        case (size)
            SZ_BYTE: begin
                tgt.addr = unit;
                tgt.pos  = {unit[1:0], word_addr[2:0]};
                tgt.be   = BE_W'(1) << unit[1:0];
            end
            SZ_HALF: begin
                tgt.addr = {unit[ADDR_W-1:1], 1'b0};
                tgt.pos  = {unit[1], word_addr[3:0]};
                tgt.be   = unit[1] ? 4'b1100 : 4'b0011;
            end
            default: begin
                tgt.addr = {unit[ADDR_W-1:2], 2'b00};
                tgt.pos  = word_addr[4:0];
                tgt.be   = '1;
            end
        endcase
    end
endmodule

// File: rtl/bb_rmw_seq.sv
// Access sequencer: latches one slave request, runs the fetch and, for
// writes, the locked write-back on the master port, then answers once.
// Assumes both sides hold a request until ready and the master returns
// the whole bus word on a read.
module bb_rmw_seq
    import bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req,
    input  logic              s_we,
    input  logic              s_wbit,
    input  logic              hit,
    input  bb_target_t        tgt,
    output logic              s_ready,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_err,
    output logic              m_req,
    output logic              m_we,
    output logic              m_lock,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [BE_W-1:0]   m_be,
    output logic [DATA_W-1:0] m_wdata,
    input  logic              m_ready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_err
);
    bb_state_e         state;
    bb_target_t        t_q;
    logic              we_q, wbit_q, err_q, bit_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] merged;

    // Fetched word with the selected bit replaced by the write bit.
    always_comb begin
        merged = (m_rdata & ~(DATA_W'(1) << t_q.pos)) |
                 (DATA_W'(wbit_q) << t_q.pos);
    end

    // State machine and capture of request and response fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            t_q    <= '0;
            we_q   <= 1'b0;
            wbit_q <= 1'b0;
            err_q  <= 1'b0;
            bit_q  <= 1'b0;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (s_req) begin
                    t_q    <= tgt;
                    we_q   <= s_we;
                    wbit_q <= s_wbit;
                    bit_q  <= 1'b0;
                    err_q  <= !hit;
                    state  <= hit ? ST_FETCH : ST_DONE;
                end
                ST_FETCH: if (m_ready) begin
                    if (m_err) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else if (we_q) begin
                        data_q <= merged;
                        state  <= ST_STORE;
                    end else begin
                        bit_q <= m_rdata[t_q.pos];
                        state <= ST_DONE;
                    end
                end
                ST_STORE: if (m_ready) begin
                    err_q <= m_err;
                    state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the registered state.
    always_comb begin
        m_req   = (state == ST_FETCH) || (state == ST_STORE);
        m_we    = (state == ST_STORE);
        m_lock  = we_q && m_req;
        m_addr  = t_q.addr;
        m_size  = t_q.size;
        m_be    = t_q.be;
        m_wdata = data_q;
        s_ready = (state == ST_DONE);
        s_rdata = {{(DATA_W-1){1'b0}}, bit_q};
        s_err   = err_q;
    end

    a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);
    a_r9_master_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_be)));
    a_r7_store_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> m_lock);
    a_r7_lock_to_store: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_lock && !m_we && m_ready && !m_err) |=> (m_req && m_we && m_lock));
    a_r8_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_we && m_ready && m_err) |=> !m_req);
    a_r5_rdata_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (s_rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/bitband_bridge.sv
// Top of the bit-band alias bridge: window decode, target mapping and the
// read-modify-write sequencer between a slave and a master bus port.
// Assumes word-aligned slave accesses and a single downstream master port.
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int                       NUM_WIN    = 2,
    parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_MAP  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*ADDR_W-1:0] TARGET_MAP = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_req,
    input  logic               s_we,
    input  logic [WADDR_W-1:0] s_word_addr,
    input  logic [1:0]         s_size,
    input  logic               s_wbit,
    output logic               s_ready,
    output logic [DATA_W-1:0]  s_rdata,
    output logic               s_err,
    output logic               m_req,
    output logic               m_we,
    output logic               m_lock,
    output logic [ADDR_W-1:0]  m_addr,
    output logic [1:0]         m_size,
    output logic [BE_W-1:0]    m_be,
    output logic [DATA_W-1:0]  m_wdata,
    input  logic               m_ready,
    input  logic [DATA_W-1:0]  m_rdata,
    input  logic               m_err
);
    bb_size_e          size_in;
    logic              dec_hit;
    logic [ADDR_W-1:0] dec_base;
    bb_target_t        tgt;

    assign size_in = bb_size_e'(s_size);

    bb_alias_decode #(
        .NUM_WIN(NUM_WIN), .ALIAS_MAP(ALIAS_MAP), .TARGET_MAP(TARGET_MAP)
    ) u_decode (
        .word_addr(s_word_addr), .size(size_in), .hit(dec_hit), .base(dec_base)
    );

    bb_lane_map u_map (
        .word_addr(s_word_addr), .size(size_in), .base(dec_base), .tgt(tgt)
    );

    bb_rmw_seq u_seq (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_wbit(s_wbit),
        .hit(dec_hit), .tgt(tgt), .s_ready(s_ready), .s_rdata(s_rdata),
        .s_err(s_err), .m_req(m_req), .m_we(m_we), .m_lock(m_lock),
        .m_addr(m_addr), .m_size(m_size), .m_be(m_be), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err)
    );

    a_r1_miss_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !dec_hit && !m_req && !s_ready) |=> !m_req);
    a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_size == 2'd0) |-> $onehot(m_be));
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_size == 2'd2) |-> (m_addr[1:0] == 2'b00 && m_be == 4'hF));
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!s_ready && !m_req && !m_lock));
endmodule

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/1ps
module tb_bitband_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req = 1'b0, s_we = 1'b0, s_wbit = 1'b0;
    logic [29:0] s_word_addr = '0;
    logic [1:0]  s_size = '0;
    logic        s_ready, s_err;
    logic [31:0] s_rdata;
    logic        m_req, m_we, m_lock;
    logic [31:0] m_addr, m_wdata;
    logic [1:0]  m_size;
    logic [3:0]  m_be;
    logic        m_ready = 1'b0, m_err = 1'b0;
    logic [31:0] m_rdata = '0;

    typedef struct { logic err; logic [31:0] data; string tag; } resp_t;
    typedef struct { logic [31:0] addr; logic we; logic lock; logic [3:0] be;
                     logic [1:0] size; logic [31:0] wdata; string tag; } mtx_t;

    resp_t       rq[$];
    mtx_t        mq[$];
    logic [31:0] mem [logic [31:0]];
    int          vectors = 0, miscompares = 0;
    int          lat = 0, wait_cnt = 0;
    logic [31:0] err_key = 32'hFFFF_FFFF;
    logic        err_on_we = 1'b0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bitband_bridge dut (
        .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we),
        .s_word_addr(s_word_addr), .s_size(s_size), .s_wbit(s_wbit),
        .s_ready(s_ready), .s_rdata(s_rdata), .s_err(s_err),
        .m_req(m_req), .m_we(m_we), .m_lock(m_lock), .m_addr(m_addr),
        .m_size(m_size), .m_be(m_be), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err)
    );

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists({a[31:2], 2'b00}) ? mem[{a[31:2], 2'b00}] : 32'h0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bus model: variable latency, error injection, compares each transfer.
    initial begin
        forever begin
            @(negedge clk);
            if (m_ready) begin
                m_ready = 1'b0; m_err = 1'b0; wait_cnt = lat;
            end else if (m_req) begin
                if (wait_cnt > 0) wait_cnt--;
                else begin
                    logic [31:0] key;
                    logic        e;
                    key = {m_addr[31:2], 2'b00};
                    e = (key == err_key) && (m_we == err_on_we);
                    if (mq.size() == 0) begin
                        vectors++; miscompares++;
                        $display("FAIL R1 unexpected master transfer actual=%h expected=none", m_addr);
                    end else begin
                        mtx_t x;
                        x = mq.pop_front();
                        check({x.tag, " master addr/we/lock/be/size"},
                              {21'b0, m_addr, m_we, m_lock, m_be, m_size},
                              {21'b0, x.addr, x.we, x.lock, x.be, x.size});
                        if (x.we) check({x.tag, " master wdata"}, {32'b0, m_wdata}, {32'b0, x.wdata});
                    end
                    if (!m_we) m_rdata = rd_mem(key);
                    else if (!e) begin
                        logic [31:0] w;
                        w = rd_mem(key);
                        for (int k = 0; k < 4; k++)
                            if (m_be[k]) w[8*k +: 8] = m_wdata[8*k +: 8];
                        mem[key] = w;
                    end
                    m_ready = 1'b1; m_err = e;
                    lat = (lat + 1) % 3;
                end
            end
        end
    end

    // Response monitor: pops the scoreboard on each s_ready.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && s_ready) begin
                if (rq.size() == 0) begin
                    vectors++; miscompares++;
                    $display("FAIL R9 unexpected response actual=1 expected=0");
                end else begin
                    resp_t r;
                    r = rq.pop_front();
                    check({r.tag, " response"}, {31'b0, s_err, s_rdata}, {31'b0, r.err, r.data});
                end
            end
        end
    end

    // Driver: predicts master transfers and response, then runs the access.
    // inj: 0 none, 1 error on fetch, 2 error on write-back.
    task automatic access(input string tag, input logic we, input logic [31:0] addr,
                          input logic [1:0] size, input logic wbit, input int inj);
        logic        hit;
        logic [31:0] base, unit, ta, word, nw;
        logic [4:0]  pos;
        logic [3:0]  be;
        hit  = (size != 2'd3) && (addr[31:25] == 7'h11 || addr[31:25] == 7'h21);
        base = (addr[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
        unit = base | {12'b0, addr[24:5]};
        case (size)
            2'd0: begin ta = unit; pos = {unit[1:0], addr[4:2]}; be = 4'b0001 << unit[1:0]; end
            2'd1: begin ta = {unit[31:1], 1'b0}; pos = {unit[1], addr[5:2]};
                        be = unit[1] ? 4'b1100 : 4'b0011; end
            default: begin ta = {unit[31:2], 2'b00}; pos = addr[6:2]; be = 4'hF; end
        endcase
        word = rd_mem(ta);
        err_key = (inj != 0) ? {ta[31:2], 2'b00} : 32'hFFFF_FFFF;
        err_on_we = (inj == 2);
        if (!hit) rq.push_back('{1'b1, 32'h0, tag});
        else begin
            mq.push_back('{ta, 1'b0, we, be, size, 32'h0, tag});
            if (inj == 1) rq.push_back('{1'b1, 32'h0, tag});
            else if (!we) rq.push_back('{1'b0, {31'b0, word[pos]}, tag});
            else begin
                nw = word; nw[pos] = wbit;
                mq.push_back('{ta, 1'b1, 1'b1, be, size, nw, tag});
                rq.push_back('{(inj == 2), 32'h0, tag});
            end
        end
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_word_addr = addr[31:2]; s_size = size; s_wbit = wbit;
        do @(negedge clk); while (!s_ready);
        s_req = 1'b0;
        err_key = 32'hFFFF_FFFF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++; miscompares++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        mem[32'h2000_0000] = 32'hA5C3_0F81;
        mem[32'h2000_0004] = 32'h0000_0000;
        mem[32'h200F_FFFC] = 32'h8000_0001;
        mem[32'h4000_0100] = 32'h1234_8765;
        repeat (3) @(negedge clk);
        check("R10 reset outputs", {61'b0, s_ready, m_req, m_lock}, 64'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", {61'b0, s_ready, m_req, m_lock}, 64'h0);

        // R5 R3 R4 reads: byte, halfword, word at several offsets
        access("R5 byte bit0",        1'b0, 32'h2200_0000, 2'd0, 1'b0, 0);
        access("R5 byte bit1",        1'b0, 32'h2200_0004, 2'd0, 1'b0, 0);
        access("R4 byte lane3 bit7",  1'b0, 32'h2200_007C, 2'd0, 1'b0, 0);
        access("R3 half upper bit15", 1'b0, 32'h2200_007C, 2'd1, 1'b0, 0);
        access("R3 half lower bit9",  1'b0, 32'h2200_0024, 2'd1, 1'b0, 0);
        access("R2 word bit31",       1'b0, 32'h2200_007C, 2'd2, 1'b0, 0);
        access("R2 window1 word",     1'b0, 32'h4200_2008, 2'd2, 1'b0, 0);
        access("R2 window top",       1'b0, 32'h23FF_FFFC, 2'd2, 1'b0, 0);
        // R6 R7 writes: set and clear, then read back
        access("R6 set byte",         1'b1, 32'h2200_00A8, 2'd0, 1'b1, 0);
        access("R6 readback set",     1'b0, 32'h2200_00A8, 2'd0, 1'b0, 0);
        access("R6 clear word bit0",  1'b1, 32'h2200_0000, 2'd2, 1'b0, 0);
        access("R6 set half",         1'b1, 32'h4200_2038, 2'd1, 1'b1, 0);
        access("R7 clear window1",    1'b1, 32'h4200_2014, 2'd2, 1'b0, 0);
        access("R6 readback clear",   1'b0, 32'h4200_2014, 2'd2, 1'b0, 0);
        // R1 R3 rejected accesses
        access("R1 below window",     1'b0, 32'h21FF_FFFC, 2'd2, 1'b0, 0);
        access("R1 above window",     1'b1, 32'h2400_0000, 2'd0, 1'b1, 0);
        access("R1 above window1",    1'b0, 32'h4400_0000, 2'd2, 1'b0, 0);
        access("R3 bad size",         1'b1, 32'h2200_0000, 2'd3, 1'b1, 0);
        // R8 master errors
        access("R8 fetch error write", 1'b1, 32'h2200_0100, 2'd2, 1'b1, 1);
        access("R8 fetch error read",  1'b0, 32'h2200_0100, 2'd2, 1'b0, 1);
        access("R8 store error",       1'b1, 32'h2200_0104, 2'd2, 1'b1, 2);
        access("R8 readback no change", 1'b0, 32'h2200_0100, 2'd2, 1'b0, 0);

        repeat (4) @(negedge clk);
        check("R9 queues drained", {32'b0, 16'(rq.size()), 16'(mq.size())}, 64'h0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule